// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single shared, open-drain serial interrupt wire. It runs on the PCI clock. It opens every polling cycle with a Start pulse, either its own or one begun by a peripheral. It then walks a train of three-clock data frames and samples the wire in the first clock of each frame. A frame that reads low means the source tied to that frame is asserted. A Stop pulse closes the cycle, and the width of that pulse tells every agent on the wire which operating mode comes next.

The sampled levels are collected during the cycle. On the last clock of the last frame they are copied together into a vector of legacy IRQ lines, an active-low SMI request, an active-low I/O-check line and four active-low PCI INTx lines. In continuous mode the host starts every cycle itself. In quiet mode the host stays idle until a peripheral pulls the wire low, and then completes the Start pulse for it. The pad is modelled as an input plus an output-enable and an output value. The host always drives the wire high for one clock before it lets go, so that each release has a sharp rising edge.

Top module: `serirq_host`

## Requirements
- R1: While reset is held, the pad is released, `irqVec` is all zero and `smiN`, `ioChkN` and `intN` are all high. The first host Start pulse begins in the clock that follows reset release.
- R2: A host-initiated Start drives the wire low for exactly 4 clocks. The host then drives it high for exactly one clock and releases it. No low pulse driven by the host is longer than 4 clocks.
- R3: Position 1 is the high-drive clock after the Start pulse. Frame k (counting from 1) samples the wire at position 3k-1, and a low sample means the source is asserted. The pad stays released from position 2 through the end of the last frame.
- R4: `irqVec` bit n carries IRQn, active high. IRQ1 is frame 2, IRQ3 to IRQ7 are frames 4 to 8, IRQ9 to IRQ12 are frames 10 to 13, and IRQ14 and IRQ15 are frames 15 and 16. Bits 0, 2, 8 and 13 are always zero.
- R5: A low sample in frame 3 drives `smiN` low. A low sample in frame 17 drives `ioChkN` low. Frames 18, 19, 20 and 21 drive `intN[0]` to `intN[3]` low.
- R6: All decoded outputs change together, and only on the clock edge that ends the last frame of a completed cycle. Low samples in frames 1, 9, 14 and in frame 22 or later have no effect on any output.
- R7: The cycle has N frames, where N = 21 + `frameSel`. Any `frameSel` value of 11 or more gives N = 32. The value is captured at the end of the Start pulse. The Stop pulse begins at position 3N+2.
- R8: The Stop pulse is 2 clocks low if `quietMode` is high on the last clock of the last frame, and 3 clocks low otherwise. One high-drive clock follows it, and then the pad is released.
- R9: After a 3-clock Stop (continuous), the pad stays released for exactly one clock and then the next host Start begins.
- R10: After a 2-clock Stop (quiet), the host never begins a Start by itself. A low level seen on the second or a later released clock makes the host drive low for 3 more clocks, drive high for one clock and then run the frames as in R3. A low level in the first released clock is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIrqIn | input | 1 | Sensed level of the shared wire |
| serIrqOe | output | 1 | Pad output enable (1 = host drives the wire) |
| serIrqOut | output | 1 | Level driven while `serIrqOe` is high |
| quietMode | input | 1 | Mode chosen for the next cycle (1 = quiet, 0 = continuous) |
| frameSel | input | 4 | Frame count select, N = 21 + value, saturating at 32 |
| irqVec | output | 16 | Decoded legacy IRQ lines, active high |
| smiN | output | 1 | Decoded SMI request, active low |
| ioChkN | output | 1 | Decoded I/O-check line, active low |
| intN | output | 4 | Decoded PCI INTA to INTD, active low |

## Verification
A frame counter that is off by one clock moves every sample into the turnaround clock of its frame. On the next commit, each asserted source then shows up on the output bit of its neighbour, or vanishes. A wrong frame-count or mode register changes where the Stop pulse starts or how wide it is, and that shows on the pad within a single cycle. A wrong idle state shows as a host Start in quiet mode, or as a missing Start in continuous mode, within two clocks of the Stop release. Each cycle is therefore checked clock by clock at the pad, and against the decoded outputs one clock before and one clock after the commit edge.

// File: rtl/serirq_pkg.sv
`timescale 1ns/1ps
package serirq_pkg;

  localparam int FRAME_IDX_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_REL,
    ST_FRAMES,
    ST_STOP,
    ST_STOP_REL
  } hostState_t;

  // strobes from the sequencer to the sample/decode datapath
  typedef struct packed {
    logic                   clearShadow;
    logic                   sampleEn;
    logic [FRAME_IDX_W-1:0] sampleIdx;
    logic                   commit;
  } dpStrobe_t;

  // frame number (1-based) carrying a legacy IRQ, 0 when the IRQ has no frame
  function automatic int irqSlot(input int irq);
    if (irq == 1) return 2;
    if ((irq >= 3 && irq <= 7) || (irq >= 9 && irq <= 12) || irq == 14 || irq == 15)
      return irq + 1;
    return 0;
  endfunction

endpackage

// File: rtl/serirq_ctrl.sv
`timescale 1ns/1ps
module serirq_ctrl
  import serirq_pkg::*;
#(
  parameter int START_CLKS = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int MIN_FRAMES = 21,
  parameter int MAX_FRAMES = 32,
  parameter int SEL_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             quietMode,
  input  logic [SEL_W-1:0] frameSel,
  output logic             padOe,
  output logic             padOut,
  output dpStrobe_t        stb
);

  localparam int CNT_W     = $clog2(START_CLKS + 1);
  localparam int FR_W      = $clog2(MAX_FRAMES + 1);
  localparam int EXTRA_MAX = MAX_FRAMES - MIN_FRAMES;

  hostState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [FR_W-1:0]  frameIdx;
  logic [FR_W-1:0]  numFrames;
  logic [FR_W-1:0]  selFrames;
  logic [1:0]       phase;
  logic             quietReg;
  logic             idleFirst;
  logic             lastFrame;
  logic [CNT_W-1:0] stopLast;

  always_comb begin
    if (int'(frameSel) > EXTRA_MAX) selFrames = FR_W'(MAX_FRAMES);
    else                            selFrames = FR_W'(MIN_FRAMES) + FR_W'(frameSel);
  end

  assign lastFrame = (frameIdx == numFrames - FR_W'(1));
  assign stopLast  = quietReg ? CNT_W'(STOP_QUIET - 1) : CNT_W'(STOP_CONT - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      frameIdx  <= '0;
      phase     <= '0;
      numFrames <= FR_W'(MAX_FRAMES);
      quietReg  <= 1'b0;
      idleFirst <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          idleFirst <= 1'b0;
          if (!quietReg) begin
            state <= ST_START;
            cnt   <= '0;
          end else if (!idleFirst && !lineIn) begin
            // a peripheral already supplied the first low clock
            state <= ST_START;
            cnt   <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt == CNT_W'(START_CLKS - 1)) begin
            state     <= ST_REL;
            numFrames <= selFrames;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_REL: begin
          state    <= ST_FRAMES;
          frameIdx <= '0;
          phase    <= '0;
        end
        ST_FRAMES: begin
          if (phase == 2'd2) begin
            phase <= '0;
            if (lastFrame) begin
              state    <= ST_STOP;
              cnt      <= '0;
              quietReg <= quietMode;
            end else begin
              frameIdx <= frameIdx + FR_W'(1);
            end
          end else begin
            phase <= phase + 2'd1;
          end
        end
        ST_STOP: begin
          if (cnt == stopLast) state <= ST_STOP_REL;
          else                 cnt   <= cnt + CNT_W'(1);
        end
        ST_STOP_REL: begin
          state     <= ST_IDLE;
          idleFirst <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    padOe  = (state == ST_START) || (state == ST_REL) ||
             (state == ST_STOP)  || (state == ST_STOP_REL);
    padOut = (state == ST_REL) || (state == ST_STOP_REL);
  end

  always_comb begin
    stb.clearShadow = (state == ST_REL);
    stb.sampleEn    = (state == ST_FRAMES) && (phase == 2'd0);
    stb.sampleIdx   = FRAME_IDX_W'(frameIdx);
    stb.commit      = (state == ST_FRAMES) && (phase == 2'd2) && lastFrame;
  end

  // consecutive host-low clocks, kept for the checks below
  logic [CNT_W:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowRun <= '0;
    else if (padOe && !padOut) lowRun <= lowRun + (CNT_W+1)'(1);
    else                       lowRun <= '0;
  end

  AST_LOW_RUN_MAX: assert property (@(posedge clk) disable iff (!rstN)
    int'(lowRun) <= START_CLKS); // R2

  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(padOe && !padOut) && !(padOe && !padOut)) |-> (padOe && padOut)); // R2

  AST_STOP_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP_REL) |-> (int'(lowRun) == (quietReg ? STOP_QUIET : STOP_CONT))); // R8

  AST_CONT_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !quietReg) |=> (state == ST_START)); // R9

  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && quietReg && lineIn) |=> (state != ST_START)); // R10

endmodule

// File: rtl/serirq_dp.sv
`timescale 1ns/1ps
module serirq_dp
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ    = 16,
  parameter int NUM_INTX   = 4,
  parameter int SMI_SLOT   = 3,
  parameter int CHK_SLOT   = 17,
  parameter int INTX_SLOT0 = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineIn,
  input  dpStrobe_t           stb,
  output logic [NUM_IRQ-1:0]  irqVec,
  output logic                smiN,
  output logic                ioChkN,
  output logic [NUM_INTX-1:0] intN
);

  logic [NUM_IRQ-1:0]  irqPend;
  logic                smiPend;
  logic                chkPend;
  logic [NUM_INTX-1:0] intPend;
  int                  idx;

  assign idx = int'(stb.sampleIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= '0;
      smiPend <= 1'b0;
      chkPend <= 1'b0;
      intPend <= '0;
      irqVec  <= '0;
      smiN    <= 1'b1;
      ioChkN  <= 1'b1;
      intN    <= '1;
    end else begin
      if (stb.clearShadow) begin
        irqPend <= '0;
        smiPend <= 1'b0;
        chkPend <= 1'b0;
        intPend <= '0;
      end else if (stb.sampleEn) begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (irqSlot(i) != 0 && idx == irqSlot(i) - 1) irqPend[i] <= ~lineIn;
        end
        if (idx == SMI_SLOT - 1) smiPend <= ~lineIn;
        if (idx == CHK_SLOT - 1) chkPend <= ~lineIn;
        for (int j = 0; j < NUM_INTX; j++) begin
          if (idx == INTX_SLOT0 - 1 + j) intPend[j] <= ~lineIn;
        end
      end
      if (stb.commit) begin
        irqVec <= irqPend;
        smiN   <= ~smiPend;
        ioChkN <= ~chkPend;
        intN   <= ~intPend;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable({irqVec, smiN, ioChkN, intN})); // R6

  AST_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (!stb.clearShadow && !stb.sampleEn)); // R6

endmodule

// File: rtl/serirq_host.sv
`timescale 1ns/1ps
module serirq_host
  import serirq_pkg::*;
#(
  parameter int START_CLKS = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int MIN_FRAMES = 21,
  parameter int MAX_FRAMES = 32,
  parameter int SEL_W      = 4,
  parameter int NUM_IRQ    = 16,
  parameter int NUM_INTX   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serIrqIn,
  output logic                serIrqOe,
  output logic                serIrqOut,
  input  logic                quietMode,
  input  logic [SEL_W-1:0]    frameSel,
  output logic [NUM_IRQ-1:0]  irqVec,
  output logic                smiN,
  output logic                ioChkN,
  output logic [NUM_INTX-1:0] intN
);

  dpStrobe_t stb;

  serirq_ctrl #(
    .START_CLKS(START_CLKS), .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT),
    .MIN_FRAMES(MIN_FRAMES), .MAX_FRAMES(MAX_FRAMES), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineIn(serIrqIn), .quietMode(quietMode),
    .frameSel(frameSel), .padOe(serIrqOe), .padOut(serIrqOut), .stb(stb)
  );

  serirq_dp #(
    .NUM_IRQ(NUM_IRQ), .NUM_INTX(NUM_INTX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(serIrqIn), .stb(stb),
    .irqVec(irqVec), .smiN(smiN), .ioChkN(ioChkN), .intN(intN)
  );

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleEn |-> !serIrqOe); // R3

endmodule

// File: tb/sim_serirq_host.sv
`timescale 1ns/1ps
module sim_serirq_host;

  logic        clk = 1'b0;
  logic        rstN;
  logic        serIrqOe, serIrqOut;
  logic        quietMode;
  logic [3:0]  frameSel;
  logic [15:0] irqVec;
  logic        smiN, ioChkN;
  logic [3:0]  intN;
  logic        devLow, devStart;
  logic        line;

  int testCount = 0;
  int failCount = 0;
  bit prevQuiet = 1'b0;

  logic [15:0] expIrq = '0;
  logic        expSmiN = 1'b1, expChkN = 1'b1;
  logic [3:0]  expIntN = 4'hF;

  always #10 clk = ~clk;

  assign line = (serIrqOe && !serIrqOut) ? 1'b0 : ((devLow || devStart) ? 1'b0 : 1'b1);

  serirq_host u0 (
    .clk(clk), .rstN(rstN), .serIrqIn(line), .serIrqOe(serIrqOe), .serIrqOut(serIrqOut),
    .quietMode(quietMode), .frameSel(frameSel), .irqVec(irqVec), .smiN(smiN),
    .ioChkN(ioChkN), .intN(intN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int framesOf(input logic [3:0] sel);
    return (sel > 4'd11) ? 32 : 21 + int'(sel);
  endfunction

  // bit k-1 of pend is frame k
  task automatic setExpected(input logic [31:0] pend);
    expIrq = '0;
    expIrq[1] = pend[1];
    expIrq[3] = pend[3];   expIrq[4] = pend[4];   expIrq[5] = pend[5];
    expIrq[6] = pend[6];   expIrq[7] = pend[7];
    expIrq[9] = pend[9];   expIrq[10] = pend[10]; expIrq[11] = pend[11];
    expIrq[12] = pend[12]; expIrq[14] = pend[14]; expIrq[15] = pend[15];
    expSmiN = ~pend[2];
    expChkN = ~pend[16];
    expIntN = ~pend[20:17];
  endtask

  function automatic logic [31:0] outWord();
    return {9'd0, intN, ioChkN, smiN, irqVec};
  endfunction

  function automatic logic [31:0] expWord();
    return {9'd0, expIntN, expChkN, expSmiN, expIrq};
  endfunction

  // entry and exit: at a negedge inside the first released clock after a Stop
  task automatic runCycle(input logic [31:0] pend, input logic qm, input logic [3:0] fsel,
                          input bit guardPulse);
    int nf = framesOf(fsel);
    int lowCnt;
    bit padBad = 1'b0;
    frameSel  = fsel;
    quietMode = qm;
    if (prevQuiet) begin
      check(!serIrqOe, "R10 pad released after quiet stop", serIrqOe, 0);
      if (guardPulse) devStart = 1'b1;
      @(negedge clk);
      devStart = 1'b0;
      check(!serIrqOe, "R10 low in first released clock ignored", serIrqOe, 0);
      @(negedge clk);
      check(!serIrqOe, "R10 host does not start in quiet mode", serIrqOe, 0);
      devStart = 1'b1;
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        devStart = 1'b0;
        check(serIrqOe && !serIrqOut, "R10 host completes peripheral start", {serIrqOe, serIrqOut}, 2);
      end
    end else begin
      check(!serIrqOe, "R9 one released clock before host start", serIrqOe, 0);
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        check(serIrqOe && !serIrqOut, "R2 host start low", {serIrqOe, serIrqOut}, 2);
      end
    end
    @(negedge clk);
    check(serIrqOe && serIrqOut, "R2 drive high after start", {serIrqOe, serIrqOut}, 3);
    for (int pos = 2; pos <= 3 * nf + 1; pos++) begin
      @(negedge clk);
      devLow = ((pos % 3) == 2) && pend[(pos + 1) / 3 - 1];
      if (serIrqOe) padBad = 1'b1;
    end
    check(!padBad, "R3 pad released during frames", padBad, 0);
    check(outWord() == expWord(), "R6 outputs hold before commit", outWord(), expWord());
    setExpected(pend);
    @(negedge clk);
    devLow = 1'b0;
    check(serIrqOe && !serIrqOut, "R7 stop begins at position 3N+2", {serIrqOe, serIrqOut}, 2);
    check(irqVec == expIrq, "R4 irq decode", irqVec, expIrq);
    check({smiN, ioChkN, intN} == {expSmiN, expChkN, expIntN}, "R5 smi/iochk/intx decode",
          {smiN, ioChkN, intN}, {expSmiN, expChkN, expIntN});
    lowCnt = 1;
    @(negedge clk);
    while (serIrqOe && !serIrqOut && lowCnt < 6) begin
      lowCnt++;
      @(negedge clk);
    end
    check(lowCnt == (qm ? 2 : 3), "R8 stop width", lowCnt, qm ? 2 : 3);
    check(serIrqOe && serIrqOut, "R8 drive high after stop", {serIrqOe, serIrqOut}, 3);
    @(negedge clk);
    prevQuiet = qm;
  endtask

  initial begin
    rstN = 1'b0; quietMode = 1'b0; frameSel = 4'd0; devLow = 1'b0; devStart = 1'b0;
    repeat (3) @(negedge clk);
    check(!serIrqOe, "R1 pad released in reset", serIrqOe, 0);
    check(outWord() == {9'd0, 4'hF, 1'b1, 1'b1, 16'h0}, "R1 outputs idle in reset",
          outWord(), {9'd0, 4'hF, 1'b1, 1'b1, 16'h0});
    rstN = 1'b1;
    // directed corners
    runCycle(32'h0, 1'b0, 4'd0, 1'b0);
    runCycle(32'h001F_FFFF, 1'b0, 4'd0, 1'b0);          // every frame of the 21 low
    runCycle(32'hFFE0_2101, 1'b0, 4'd11, 1'b0);          // only unassigned frames, R6
    check(outWord() == {9'd0, 4'hF, 1'b1, 1'b1, 16'h0}, "R6 unassigned frames ignored",
          outWord(), {9'd0, 4'hF, 1'b1, 1'b1, 16'h0});
    runCycle(32'h0000_0004, 1'b1, 4'd3, 1'b0);           // SMI only, switch to quiet
    runCycle(32'h001E_0002, 1'b1, 4'd15, 1'b1);          // quiet, guard pulse, N clamps to 32
    runCycle(32'h0000_D6A8, 1'b0, 4'd1, 1'b0);           // quiet start, back to continuous
    void'($urandom(32'd2024));
    for (int n = 0; n < 20; n++) begin
      runCycle($urandom, 1'($urandom), 4'($urandom), 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule